// File: doc/BRIEF.md
# Five-Pin Multiplexed GPIO Port

This block is the general-purpose I/O port of a small microcontroller. It exposes five pads, each with an output latch and a direction bit. Software reaches them through two register addresses on an 8-bit bus, one for port data and one for direction, using write, read, bit-set and bit-clear strobes. A read of the data address returns the synchronized pad levels, not the latch contents. A write changes only the latch.

The port shares its pads with an analog comparator block and a voltage reference. A 3-bit comparator mode selects, from a fixed table, which of pads 0 to 3 are analog inputs; those read as zero. One mode hands pads 3 and 4 to the two comparator outputs. A reference-output enable takes pad 2 off the digital driver. Pad 4 can only pull low.

Bit set and bit clear work as read-modify-write. The whole port is read, one bit is changed, and the result goes back into the latch. Every input pad therefore copies its sensed level, or zero if it is masked as analog, into its latch.

Top module: `gpio_mux_port`

## Requirements
- R1: While reset is active, every direction bit becomes 1 and every latch bit becomes 0, so no pad is enabled (pad_oe = 0) and the direction register reads 0x1F.
- R2: A write to the direction address (addr = 1) stores wr_data[4:0]. A read of that address returns the stored bits, with bits 7..5 always 0.
- R3: For pads 0..3, pad_oe is the inverse of the direction bit, and pad_out equals the drive source while pad_oe is 1 (0 otherwise). The drive source is the latch bit outside the cases of R7 and R8.
- R4: A write to the data address (addr = 0) changes only the latch. A read of that address with rd_en = 1 returns the pad levels delayed by two clock edges, not the latch. With rd_en = 0, rd_data is 0.
- R5: Pads flagged as analog read as 0. The mask on pads 3..0 by cmp_mode is 0, 1, 2 → 1111; 3 → 1011; 4 → 1001; 5 → 0011; 6 → 0011; 7 → 0000. Pad 4 is never masked.
- R6: Pad 4 is open-drain. pad_out[4] is always 0, and pad_oe[4] is 1 only when its direction bit is 0 and its drive source is 0.
- R7: With cmp_mode = 6, the drive source of pad 3 is cmp_out[0] and that of pad 4 is cmp_out[1]. Each still drives only when its direction bit is 0.
- R8: While vref_en is 1, pad_oe[2] is 0 whatever its direction bit.
- R9: A bit set or clear on the data address writes the current read value, with bit bit_sel set or cleared, into the whole latch. Input pads copy their sensed level, and masked pads copy 0.
- R10: A bit set or clear on the direction address changes only bit bit_sel of the direction register. A bit operation with bit_sel ≥ 5 has no effect.
- R11: When strobes coincide, wr_en takes precedence over bit operations, and bit clear takes precedence over bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | Register select: 0 port data, 1 direction |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; gates rd_data |
| rd_data | output | 8 | Read data (combinational) |
| bset_en | input | 1 | Bit-set strobe |
| bclr_en | input | 1 | Bit-clear strobe |
| bit_sel | input | 3 | Bit index for set/clear |
| cmp_mode | input | 3 | Comparator mode field |
| cmp_out | input | 2 | Comparator results for pads 3 and 4 |
| vref_en | input | 1 | Reference output enable on pad 2 |
| pad_in | input | 5 | Sensed pad levels |
| pad_out | output | 5 | Pad output values |
| pad_oe | output | 5 | Pad output enables |

## Verification
The bench goes after read-modify-write on input pads. A design that cleared or set only the addressed bit would leave the other latch bits at their old values instead of copying the pads. A design that used the raw pad instead of the masked read would load ones from analog pads. It checks the open-drain pad with a latch of 1, where a push-pull driver would drive high. It also checks the reference pad with its direction bit cleared, where a port that only obeyed direction would still drive. It samples the read path one and two edges after a pad change, which exposes a synchronizer of the wrong depth, and it applies a bit index above the port width, which a careless decoder would wrap onto a real pin.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic {
      REG_DATA = 1'b0,
      REG_DIR  = 1'b1
   } gpio_reg_e;

   localparam int unsigned ANA_W = 4;

   // analog-input mask on pads 3..0 for each comparator mode
   function automatic logic [ANA_W-1:0] ana_mask(input logic [2:0] mode);
      logic [ANA_W-1:0] m;
      case (mode)
         3'd0, 3'd1, 3'd2: m = 4'b1111;
         3'd3:             m = 4'b1011;
         3'd4:             m = 4'b1001;
         3'd5, 3'd6:       m = 4'b0011;
         default:          m = 4'b0000;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
   parameter int unsigned NPIN         = 5,
   parameter int unsigned OD_PIN       = 4,
   parameter int unsigned VREF_PIN     = 2,
   parameter int unsigned CMP_PIN_A    = 3,
   parameter int unsigned CMP_PIN_B    = 4,
   parameter logic [2:0]  CMP_OUT_MODE = 3'd6
) (
   input  logic [NPIN-1:0] dir_q,
   input  logic [NPIN-1:0] lat_q,
   input  logic [2:0]      cmp_mode,
   input  logic [1:0]      cmp_out,
   input  logic            vref_en,
   output logic [NPIN-1:0] pad_out,
   output logic [NPIN-1:0] pad_oe
);
   logic cmp_drive;
   assign cmp_drive = (cmp_mode == CMP_OUT_MODE);

   for (genvar i = 0; i < int'(NPIN); i++) begin : g_pin
      logic src;
      logic en;

      if (i == int'(CMP_PIN_A)) begin : g_src_ca
         assign src = cmp_drive ? cmp_out[0] : lat_q[i];
      end else if (i == int'(CMP_PIN_B)) begin : g_src_cb
         assign src = cmp_drive ? cmp_out[1] : lat_q[i];
      end else begin : g_src_lat
         assign src = lat_q[i];
      end

      if (i == int'(VREF_PIN)) begin : g_en_ref
         assign en = ~dir_q[i] & ~vref_en;
      end else begin : g_en_std
         assign en = ~dir_q[i];
      end

      if (i == int'(OD_PIN)) begin : g_open_drain
         assign pad_oe[i]  = en & ~src;
         assign pad_out[i] = 1'b0;
      end else begin : g_push_pull
         assign pad_oe[i]  = en;
         assign pad_out[i] = en & src;
      end
   end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned NPIN   = 5,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned SEL_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  gpio_reg_e         reg_sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              bset_en,
   input  logic              bclr_en,
   input  logic [SEL_W-1:0]  bit_sel,
   input  logic [NPIN-1:0]   pin_rd,
   output logic [NPIN-1:0]   lat_q,
   output logic [NPIN-1:0]   dir_q
);
   logic [NPIN-1:0] sel_oh;
   logic [NPIN-1:0] rmw_base;
   logic [NPIN-1:0] rmw_next;
   logic            bit_op;

   assign sel_oh   = NPIN'(1) << bit_sel;
   assign bit_op   = (bset_en | bclr_en) & (|sel_oh);
   assign rmw_base = (reg_sel == REG_DIR) ? dir_q : pin_rd;
   assign rmw_next = bclr_en ? (rmw_base & ~sel_oh) : (rmw_base | sel_oh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
         dir_q <= '1;
      end else if (wr_en) begin
         if (reg_sel == REG_DIR) dir_q <= wr_data[NPIN-1:0];
         else                    lat_q <= wr_data[NPIN-1:0];
      end else if (bit_op) begin
         if (reg_sel == REG_DIR) dir_q <= rmw_next;
         else                    lat_q <= rmw_next;
      end
   end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned NPIN         = 5,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned OD_PIN       = 4,
   parameter int unsigned VREF_PIN     = 2,
   parameter int unsigned CMP_PIN_A    = 3,
   parameter int unsigned CMP_PIN_B    = 4,
   parameter logic [2:0]  CMP_OUT_MODE = 3'd6,
   localparam int unsigned SEL_W       = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              bset_en,
   input  logic              bclr_en,
   input  logic [SEL_W-1:0]  bit_sel,
   input  logic [2:0]        cmp_mode,
   input  logic [1:0]        cmp_out,
   input  logic              vref_en,
   input  logic [NPIN-1:0]   pad_in,
   output logic [NPIN-1:0]   pad_out,
   output logic [NPIN-1:0]   pad_oe
);
   if (NPIN < ANA_W + 1 || NPIN > DATA_W) begin : g_bad_npin
      $error("gpio_mux_port: NPIN out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_mux_port: SYNC_STAGES must be at least 2");
   end
   if (OD_PIN >= NPIN || VREF_PIN >= NPIN || CMP_PIN_A >= NPIN || CMP_PIN_B >= NPIN) begin : g_bad_pin
      $error("gpio_mux_port: special pin index out of range");
   end

   gpio_reg_e       reg_sel;
   logic [NPIN-1:0] pin_sync;
   logic [NPIN-1:0] ana_msk;
   logic [NPIN-1:0] pin_rd;
   logic [NPIN-1:0] lat_q;
   logic [NPIN-1:0] dir_q;

   assign reg_sel = gpio_reg_e'(addr);
   assign ana_msk = NPIN'(ana_mask(cmp_mode));
   assign pin_rd  = pin_sync & ~ana_msk;

   gpio_sync #(
      .WIDTH (NPIN),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_in),
      .q    (pin_sync)
   );

   gpio_port_regs #(
      .NPIN  (NPIN),
      .DATA_W(DATA_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .reg_sel(reg_sel),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .bset_en(bset_en),
      .bclr_en(bclr_en),
      .bit_sel(bit_sel),
      .pin_rd (pin_rd),
      .lat_q  (lat_q),
      .dir_q  (dir_q)
   );

   gpio_pad_drv #(
      .NPIN        (NPIN),
      .OD_PIN      (OD_PIN),
      .VREF_PIN    (VREF_PIN),
      .CMP_PIN_A   (CMP_PIN_A),
      .CMP_PIN_B   (CMP_PIN_B),
      .CMP_OUT_MODE(CMP_OUT_MODE)
   ) u_drv (
      .dir_q   (dir_q),
      .lat_q   (lat_q),
      .cmp_mode(cmp_mode),
      .cmp_out (cmp_out),
      .vref_en (vref_en),
      .pad_out (pad_out),
      .pad_oe  (pad_oe)
   );

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         if (reg_sel == REG_DIR) rd_data[NPIN-1:0] = dir_q;
         else                    rd_data[NPIN-1:0] = pin_rd;
      end
   end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int unsigned NPIN     = 5,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned OD_PIN   = 4,
   parameter int unsigned VREF_PIN = 2,
   localparam int unsigned SEL_W   = $clog2(DATA_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              bset_en,
   input logic              bclr_en,
   input logic [SEL_W-1:0]  bit_sel,
   input logic              vref_en,
   input logic [NPIN-1:0]   pad_out,
   input logic [NPIN-1:0]   pad_oe,
   input logic [NPIN-1:0]   lat_q,
   input logic [NPIN-1:0]   dir_q
);
   // R1
   reset_dir_chk: assert property (@(posedge clk) !rst_n |=> (dir_q == '1) && (pad_oe == '0));

   // R2
   dir_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr) |-> (rd_data[DATA_W-1:NPIN] == '0));

   // R3
   oe_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & dir_q) == '0);

   // R4
   latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr) |=> (lat_q == $past(wr_data[NPIN-1:0])));

   // R6
   open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe[OD_PIN] |-> !pad_out[OD_PIN]);

   // R8
   vref_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vref_en |-> !pad_oe[VREF_PIN]);

   // R9
   bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bset_en && !bclr_en && !wr_en && !addr && (int'(bit_sel) < int'(NPIN)))
      |=> |(lat_q & (NPIN'(1) << $past(bit_sel))));

   // R11
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bset_en && bclr_en && !wr_en && addr && (int'(bit_sel) < int'(NPIN)))
      |=> !(|(dir_q & (NPIN'(1) << $past(bit_sel)))));
endmodule

bind gpio_mux_port gpio_port_chk #(
   .NPIN    (NPIN),
   .DATA_W  (DATA_W),
   .OD_PIN  (OD_PIN),
   .VREF_PIN(VREF_PIN)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .addr   (addr),
   .wr_en  (wr_en),
   .wr_data(wr_data),
   .rd_en  (rd_en),
   .rd_data(rd_data),
   .bset_en(bset_en),
   .bclr_en(bclr_en),
   .bit_sel(bit_sel),
   .vref_en(vref_en),
   .pad_out(pad_out),
   .pad_oe (pad_oe),
   .lat_q  (lat_q),
   .dir_q  (dir_q)
);

// File: tb/gpio_mux_port_tb.sv
module gpio_mux_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       bset_en = 1'b0;
   logic       bclr_en = 1'b0;
   logic [2:0] bit_sel = '0;
   logic [2:0] cmp_mode = 3'd0;
   logic [1:0] cmp_out = '0;
   logic       vref_en = 1'b0;
   logic [4:0] pad_in = '0;
   logic [4:0] pad_out;
   logic [4:0] pad_oe;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #4 clk = ~clk;

   gpio_mux_port u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .bset_en(bset_en), .bclr_en(bclr_en),
      .bit_sel(bit_sel), .cmp_mode(cmp_mode), .cmp_out(cmp_out), .vref_en(vref_en),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   // {mode, vref, cmp_out, dir, latch, pins, exp_oe, exp_out, exp_rd}
   localparam int NV = 12;
   localparam logic [38:0] VEC [NV] = '{
      {3'd7, 1'b0, 2'b00, 5'h00, 5'h0A, 5'h15, 5'h1F, 5'h0A, 8'h15},
      {3'd7, 1'b0, 2'b00, 5'h00, 5'h1F, 5'h00, 5'h0F, 5'h0F, 8'h00},
      {3'd7, 1'b0, 2'b00, 5'h1F, 5'h1F, 5'h1F, 5'h00, 5'h00, 8'h1F},
      {3'd0, 1'b0, 2'b00, 5'h1F, 5'h00, 5'h1F, 5'h00, 5'h00, 8'h10},
      {3'd3, 1'b0, 2'b00, 5'h1F, 5'h00, 5'h1F, 5'h00, 5'h00, 8'h14},
      {3'd4, 1'b0, 2'b00, 5'h1F, 5'h00, 5'h1F, 5'h00, 5'h00, 8'h16},
      {3'd5, 1'b0, 2'b00, 5'h1F, 5'h00, 5'h1F, 5'h00, 5'h00, 8'h1C},
      {3'd6, 1'b0, 2'b01, 5'h00, 5'h00, 5'h0C, 5'h1F, 5'h08, 8'h0C},
      {3'd6, 1'b0, 2'b10, 5'h00, 5'h1F, 5'h00, 5'h0F, 5'h07, 8'h00},
      {3'd6, 1'b0, 2'b11, 5'h18, 5'h00, 5'h03, 5'h07, 5'h00, 8'h00},
      {3'd7, 1'b1, 2'b00, 5'h00, 5'h1F, 5'h00, 5'h0B, 5'h0B, 8'h00},
      {3'd2, 1'b0, 2'b00, 5'h00, 5'h05, 5'h1F, 5'h1F, 5'h05, 8'h10}
   };

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic reg_wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bit_op(input logic a, input logic set, input logic clr, input logic [2:0] b);
      @(negedge clk);
      addr = a; bit_sel = b; bset_en = set; bclr_en = clr;
      @(negedge clk);
      bset_en = 1'b0; bclr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic a, output logic [7:0] d);
      addr = a; rd_en = 1'b1;
      #1 d = rd_data;
      rd_en = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
         finish_run();
      end
   end

   initial begin
      logic [7:0] rv;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 oe in reset", {3'b0, pad_oe}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      reg_rd(1'b1, rv);
      chk("R1 dir reset", rv, 8'h1F);
      chk("R1 oe after reset", {3'b0, pad_oe}, 8'h00);
      cmp_mode = 3'd7;
      reg_wr(1'b1, 8'h00);
      chk("R1 latch reset out", {3'b0, pad_out}, 8'h00);
      chk("R1 latch reset oe", {3'b0, pad_oe}, 8'h1F);

      // vector table: R3 R5 R6 R7 R8
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         cmp_mode = VEC[v][38:36];
         vref_en  = VEC[v][35];
         cmp_out  = VEC[v][34:33];
         pad_in   = VEC[v][22:18];
         reg_wr(1'b1, {3'b0, VEC[v][32:28]});
         reg_wr(1'b0, {3'b0, VEC[v][27:23]});
         settle();
         chk($sformatf("R3/R6/R7/R8 oe vec %0d", v), {3'b0, pad_oe}, {3'b0, VEC[v][17:13]});
         chk($sformatf("R3/R6/R7 out vec %0d", v), {3'b0, pad_out}, {3'b0, VEC[v][12:8]});
         reg_rd(1'b0, rv);
         chk($sformatf("R4/R5 read vec %0d", v), rv, VEC[v][7:0]);
      end
      vref_en = 1'b0; cmp_out = '0;

      // R2 upper direction bits
      reg_wr(1'b1, 8'hFF);
      reg_rd(1'b1, rv);
      chk("R2 dir high bits zero", rv, 8'h1F);

      // R4 read returns pins, write touches latch, two-edge delay, rd_en gate
      cmp_mode = 3'd7; pad_in = 5'h0A;
      reg_wr(1'b0, 8'h15);
      settle();
      reg_rd(1'b0, rv);
      chk("R4 read pins not latch", rv, 8'h0A);
      #1 chk("R4 rd_en low gives zero", rd_data, 8'h00);
      @(negedge clk); pad_in = 5'h11;
      @(posedge clk); #1;
      reg_rd(1'b0, rv);
      chk("R4 one edge still old", rv, 8'h0A);
      @(posedge clk); #1;
      reg_rd(1'b0, rv);
      chk("R4 two edges new", rv, 8'h11);
      reg_wr(1'b1, 8'h00);
      chk("R4 latch drives", {3'b0, pad_out}, 8'h05);

      // R9 rmw copies input pads
      reg_wr(1'b1, 8'h1F);
      reg_wr(1'b0, 8'h00);
      pad_in = 5'h1A;
      settle();
      bit_op(1'b0, 1'b1, 1'b0, 3'd0);
      reg_wr(1'b1, 8'h00);
      chk("R9 set copies pads out", {3'b0, pad_out}, 8'h0B);
      chk("R9 set copies pads oe", {3'b0, pad_oe}, 8'h0F);

      // R9 masked pads copy zero
      reg_wr(1'b1, 8'h1F);
      reg_wr(1'b0, 8'h0F);
      cmp_mode = 3'd0; pad_in = 5'h1F;
      settle();
      bit_op(1'b0, 1'b0, 1'b1, 3'd4);
      cmp_mode = 3'd7;
      reg_wr(1'b1, 8'h00);
      chk("R9 masked copy zero out", {3'b0, pad_out}, 8'h00);
      chk("R9 masked copy zero oe", {3'b0, pad_oe}, 8'h1F);

      // R10 out-of-range bit index ignored
      reg_wr(1'b1, 8'h1F);
      bit_op(1'b0, 1'b1, 1'b0, 3'd5);
      bit_op(1'b1, 1'b0, 1'b1, 3'd6);
      reg_rd(1'b1, rv);
      chk("R10 bit 6 on dir ignored", rv, 8'h1F);
      reg_wr(1'b1, 8'h00);
      chk("R10 bit 5 on data ignored", {3'b0, pad_out}, 8'h00);

      // R10 single direction bit
      reg_wr(1'b1, 8'h1F);
      bit_op(1'b1, 1'b0, 1'b1, 3'd2);
      reg_rd(1'b1, rv);
      chk("R10 dir bit clear", rv, 8'h1B);

      // R11 priorities
      bit_op(1'b1, 1'b1, 1'b1, 3'd0);
      reg_rd(1'b1, rv);
      chk("R11 clear beats set", rv, 8'h1A);
      @(negedge clk);
      addr = 1'b1; wr_data = 8'h04; wr_en = 1'b1; bset_en = 1'b1; bit_sel = 3'd0;
      @(negedge clk);
      wr_en = 1'b0; bset_en = 1'b0;
      reg_rd(1'b1, rv);
      chk("R11 write beats bit op", rv, 8'h04);

      finish_run();
   end
endmodule